// File: doc/BRIEF.md
# Hall-Synchronized Modulation Sequencer

This block turns the three digital Hall sensor lines of a brushless motor into modulation table pointers for all three phases. It measures how many clock cycles each 60-degree electrical segment lasts, that is, the time between two accepted Hall transitions. It then splits the following segment into 32 equal steps, each one thirty-second of the segment just measured. Every accepted Hall transition snaps the sequence back to the first step of the sector that the new Hall code names. Between transitions the step counter runs freely and rolls over into the next sector.

Each phase pointer is a sector (0 to 5) plus a step (0 to 31). The pointer includes a 5-bit lead offset, which advances the phase by up to about 58 electrical degrees. The three phases sit 120 degrees apart. A mode flag tells the downstream waveform stage whether to use sine drive or 120-degree block drive. Block drive is forced whenever software deselects sine drive, whenever the rotor turns too slowly, and whenever the interval counter saturates because the rotor has stalled. The sine table and the amplitude scaling sit outside this block.

Top module: `hall_mod_seq`

## Requirements
- R1: `rst_n` is asynchronous and active low, and its release is synchronised through two flops. While reset is held, and until that release reaches the logic, the base position is sector 0 step 0, `sine_mode_o` is 0 and `stall_o` is 0.
- R2: An accepted edge registers an interval equal to the number of clock cycles since the previous accepted edge. The step period becomes that interval shifted right by 5 bits, with a floor of 1. In sine mode the step index rises by one every step period.
- R3: On the clock edge that accepts a Hall transition, the base step goes to 0 and the base sector becomes the sector mapped from the new Hall code, whatever the previous position was.
- R4: If no edge arrives, step 31 is followed by step 0 of the next sector (sector 5 wraps to 0). The step period stays the same.
- R5: When an accepted edge falls in the same cycle as a step roll-over, the edge wins and the sector comes from the Hall code.
- R6: With `dir_i`=0 the Hall codes map to sectors as follows: 001→0, 011→1, 010→2, 110→3, 100→4, 101→5. With `dir_i`=1 the code that maps to s in forward order maps to (6−s) mod 6.
- R7: The Hall codes 000 and 111 are never accepted. They leave position, interval and timing untouched. The next valid code that differs from the last accepted code is accepted as an edge.
- R8: The U pointer is P = (32·sector + step + lead) mod 192. V is (P+128) mod 192 and W is (P+64) mod 192. Each output sector is pointer/32 and each output step is pointer mod 32.
- R9: With `sine_sel_i`=0, `sine_mode_o` is 0. In any cycle that follows a block-drive cycle, the base step is 0.
- R10: `sine_mode_o` is 0 whenever the last registered interval exceeds SLOW_LIMIT, or the running count since the last edge has reached SLOW_LIMIT.
- R11: The interval counter saturates at 2^CNT_W−1. `stall_o` is 1 exactly while the counter is saturated. An edge after a stall registers the saturated value, so block drive continues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_i | input | 3 | Synchronised Hall code {H2,H1,H0} |
| dir_i | input | 1 | Sector order select, 1 = descending |
| lead_i | input | STEP_BITS | Lead offset in steps |
| sine_sel_i | input | 1 | 1 requests sine drive |
| sector_u_o | output | 3 | Phase U sector |
| step_u_o | output | STEP_BITS | Phase U step |
| sector_v_o | output | 3 | Phase V sector |
| step_v_o | output | STEP_BITS | Phase V step |
| sector_w_o | output | 3 | Phase W sector |
| step_w_o | output | STEP_BITS | Phase W step |
| sine_mode_o | output | 1 | 1 = sine drive, 0 = block drive |
| stall_o | output | 1 | Interval counter saturated |

## Verification
A Hall edge and a step roll-over can land in the same cycle. The bench provokes this by spacing edges exactly 32 step periods apart, so the 32nd step expires on the cycle that accepts the edge. At that point it presents a Hall code two sectors ahead rather than one. The sector that results shows which action won. It must be the Hall-mapped sector with step 0, and a cycle-level reference model checks the same case throughout the random phase.

// File: rtl/hms_pkg.sv
package hms_pkg;

  typedef enum logic {
    DRV_BLOCK = 1'b0,
    DRV_SINE  = 1'b1
  } drive_e;

  localparam int NUM_SECTORS = 6;

  // A code is usable only when the three lines disagree.
  function automatic logic hall_ok(input logic [2:0] code);
    return (code != 3'b000) && (code != 3'b111);
  endfunction

  // Forward mapping; descending order mirrors it around sector 0.
  function automatic logic [2:0] hall_sector(input logic [2:0] code, input logic rev);
    logic [2:0] s;
    case (code)
      3'b001:  s = 3'd0;
      3'b011:  s = 3'd1;
      3'b010:  s = 3'd2;
      3'b110:  s = 3'd3;
      3'b100:  s = 3'd4;
      3'b101:  s = 3'd5;
      default: s = 3'd0;
    endcase
    if (rev && (s != 3'd0)) s = 3'd6 - s;
    return s;
  endfunction

endpackage

// File: rtl/hms_rst_sync.sv
module hms_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/hms_interval_timer.sv
module hms_interval_timer #(
  parameter int CNT_W      = 18,
  parameter int SLOW_LIMIT = 131072,
  parameter int STEP_BITS  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_i,
  output logic [CNT_W-1:0] per_o,
  output logic             slow_o,
  output logic             stall_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] SLOW_C  = CNT_W'(SLOW_LIMIT);
  localparam logic [CNT_W-1:0] PER_RST = CNT_MAX >> STEP_BITS;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] intv_q, intv_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic [CNT_W-1:0] cnt_inc, shifted;

  always_comb begin
    cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    shifted = cnt_inc >> STEP_BITS;
    cnt_d   = cnt_inc;
    intv_d  = intv_q;
    per_d   = per_q;
    if (edge_i) begin
      cnt_d  = '0;
      intv_d = cnt_inc;
      per_d  = (shifted == '0) ? CNT_W'(1) : shifted;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      intv_q <= CNT_MAX;
      per_q  <= PER_RST;
    end else begin
      cnt_q  <= cnt_d;
      intv_q <= intv_d;
      per_q  <= per_d;
    end
  end

  assign per_o   = per_q;
  assign slow_o  = (intv_q > SLOW_C) || (cnt_q >= SLOW_C);
  assign stall_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/hms_step_gen.sv
module hms_step_gen #(
  parameter int CNT_W     = 18,
  parameter int STEP_BITS = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 edge_i,
  input  logic [2:0]           edge_sector_i,
  input  logic                 run_i,
  input  logic [CNT_W-1:0]     per_i,
  output logic [2:0]           sector_o,
  output logic [STEP_BITS-1:0] step_o
);
  localparam logic [STEP_BITS-1:0] STEP_LAST = {STEP_BITS{1'b1}};

  logic [CNT_W-1:0]     tick_q, tick_d;
  logic [STEP_BITS-1:0] step_q, step_d;
  logic [2:0]           sector_q, sector_d;
  logic                 tick_en, step_done;

  assign tick_en   = run_i && !edge_i;
  assign step_done = (tick_q == per_i - 1'b1);

  always_comb begin
    tick_d   = tick_q;
    step_d   = step_q;
    sector_d = sector_q;
    if (edge_i) begin
      tick_d   = '0;
      step_d   = '0;
      sector_d = edge_sector_i;
    end else if (!tick_en) begin
      tick_d = '0;
      step_d = '0;
    end else if (step_done) begin
      tick_d = '0;
      step_d = step_q + 1'b1;
      if (step_q == STEP_LAST)
        sector_d = (sector_q == 3'd5) ? 3'd0 : sector_q + 3'd1;
    end else begin
      tick_d = tick_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q   <= '0;
      step_q   <= '0;
      sector_q <= '0;
    end else begin
      tick_q   <= tick_d;
      step_q   <= step_d;
      sector_q <= sector_d;
    end
  end

  assign sector_o = sector_q;
  assign step_o   = step_q;
endmodule

// File: rtl/hms_phase_map.sv
module hms_phase_map #(
  parameter int STEP_BITS = 5
) (
  input  logic [2:0]           sector_i,
  input  logic [STEP_BITS-1:0] step_i,
  input  logic [STEP_BITS-1:0] lead_i,
  output logic [2:0]           sector_o [3],
  output logic [STEP_BITS-1:0] step_o   [3]
);
  localparam int STEPS = 1 << STEP_BITS;
  localparam int POS_W = STEP_BITS + 4;
  localparam logic [POS_W-1:0] TURN = POS_W'(6 * STEPS);

  logic [POS_W-1:0] raw, base;

  always_comb begin
    raw  = (POS_W'(sector_i) << STEP_BITS) + POS_W'(step_i) + POS_W'(lead_i);
    base = (raw >= TURN) ? raw - TURN : raw;
  end

  for (genvar g = 0; g < 3; g++) begin : g_phase
    localparam int OFF = (g == 0) ? 0 : ((g == 1) ? 4 * STEPS : 2 * STEPS);
    logic [POS_W-1:0] sum, pos;
    always_comb begin
      sum = base + POS_W'(OFF);
      pos = (sum >= TURN) ? sum - TURN : sum;
    end
    assign sector_o[g] = pos[STEP_BITS+2:STEP_BITS];
    assign step_o[g]   = pos[STEP_BITS-1:0];
  end
endmodule

// File: rtl/hall_mod_seq.sv
module hall_mod_seq
  import hms_pkg::*;
#(
  parameter int CNT_W      = 18,
  parameter int SLOW_LIMIT = 131072,
  parameter int STEP_BITS  = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           hall_i,
  input  logic                 dir_i,
  input  logic [STEP_BITS-1:0] lead_i,
  input  logic                 sine_sel_i,
  output logic [2:0]           sector_u_o,
  output logic [STEP_BITS-1:0] step_u_o,
  output logic [2:0]           sector_v_o,
  output logic [STEP_BITS-1:0] step_v_o,
  output logic [2:0]           sector_w_o,
  output logic [STEP_BITS-1:0] step_w_o,
  output logic                 sine_mode_o,
  output logic                 stall_o
);
  logic                 rst_sync_n;
  logic [2:0]           hall_q;
  logic                 hall_edge;
  logic [2:0]           edge_sector;
  logic [CNT_W-1:0]     step_per;
  logic                 too_slow;
  logic                 stalled;
  drive_e               mode;
  logic [2:0]           base_sector;
  logic [STEP_BITS-1:0] base_step;
  logic [2:0]           ph_sector [3];
  logic [STEP_BITS-1:0] ph_step   [3];

  hms_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  // Last accepted Hall code; invalid codes never load it.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)    hall_q <= 3'b000;
    else if (hall_edge) hall_q <= hall_i;
  end

  assign hall_edge   = hall_ok(hall_i) && (hall_i != hall_q);
  assign edge_sector = hall_sector(hall_i, dir_i);

  hms_interval_timer #(
    .CNT_W      (CNT_W),
    .SLOW_LIMIT (SLOW_LIMIT),
    .STEP_BITS  (STEP_BITS)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .edge_i  (hall_edge),
    .per_o   (step_per),
    .slow_o  (too_slow),
    .stall_o (stalled)
  );

  assign mode = (sine_sel_i && !too_slow) ? DRV_SINE : DRV_BLOCK;

  hms_step_gen #(
    .CNT_W     (CNT_W),
    .STEP_BITS (STEP_BITS)
  ) u_steps (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .edge_i        (hall_edge),
    .edge_sector_i (edge_sector),
    .run_i         (mode == DRV_SINE),
    .per_i         (step_per),
    .sector_o      (base_sector),
    .step_o        (base_step)
  );

  hms_phase_map #(
    .STEP_BITS (STEP_BITS)
  ) u_map (
    .sector_i (base_sector),
    .step_i   (base_step),
    .lead_i   (lead_i),
    .sector_o (ph_sector),
    .step_o   (ph_step)
  );

  assign sector_u_o  = ph_sector[0];
  assign step_u_o    = ph_step[0];
  assign sector_v_o  = ph_sector[1];
  assign step_v_o    = ph_step[1];
  assign sector_w_o  = ph_sector[2];
  assign step_w_o    = ph_step[2];
  assign sine_mode_o = (mode == DRV_SINE);
  assign stall_o     = stalled;
endmodule

// File: rtl/hall_mod_seq_chk.sv
module hall_mod_seq_chk #(
  parameter int STEP_BITS = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2:0]           hall_i,
  input logic [STEP_BITS-1:0] lead_i,
  input logic                 sine_sel_i,
  input logic                 sine_mode_o,
  input logic                 stall_o,
  input logic [2:0]           sector_u_o,
  input logic [STEP_BITS-1:0] step_u_o
);
  AST_SQUARE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    !sine_sel_i |-> !sine_mode_o); // R9

  AST_SQUARE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!sine_mode_o) && (lead_i == '0)) |-> (step_u_o == '0)); // R9

  AST_SECTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sector_u_o < 3'd6); // R8

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    ((lead_i == '0) && ($past(lead_i) == '0) && $past(sine_mode_o)) |->
      ((step_u_o == $past(step_u_o)) || (step_u_o == STEP_BITS'($past(step_u_o) + 1'b1)) ||
       (step_u_o == '0))); // R2

  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> !sine_mode_o); // R11

  AST_STALL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && $stable(hall_i)) |=> stall_o); // R11
endmodule

bind hall_mod_seq hall_mod_seq_chk #(.STEP_BITS(STEP_BITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hall_i      (hall_i),
  .lead_i      (lead_i),
  .sine_sel_i  (sine_sel_i),
  .sine_mode_o (sine_mode_o),
  .stall_o     (stall_o),
  .sector_u_o  (sector_u_o),
  .step_u_o    (step_u_o)
);

// File: tb/hall_mod_seq_tb.sv
`timescale 1ns/1ps
module hall_mod_seq_tb;
  localparam int CW    = 10;
  localparam int SLOW  = 600;
  localparam int CMAX  = (1 << CW) - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hall_i = 3'b000;
  logic       dir_i = 1'b0;
  logic [4:0] lead_i = 5'd0;
  logic       sine_sel_i = 1'b0;
  logic [2:0] sector_u_o, sector_v_o, sector_w_o;
  logic [4:0] step_u_o, step_v_o, step_w_o;
  logic       sine_mode_o, stall_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  hall_mod_seq #(.CNT_W(CW), .SLOW_LIMIT(SLOW), .STEP_BITS(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .hall_i(hall_i), .dir_i(dir_i), .lead_i(lead_i),
    .sine_sel_i(sine_sel_i), .sector_u_o(sector_u_o), .step_u_o(step_u_o),
    .sector_v_o(sector_v_o), .step_v_o(step_v_o), .sector_w_o(sector_w_o),
    .step_w_o(step_w_o), .sine_mode_o(sine_mode_o), .stall_o(stall_o)
  );

  function automatic int map_sector(input logic [2:0] h, input logic rev);
    int s;
    case (h)
      3'b001: s = 0; 3'b011: s = 1; 3'b010: s = 2;
      3'b110: s = 3; 3'b100: s = 4; 3'b101: s = 5;
      default: s = 0;
    endcase
    if (rev) s = (6 - s) % 6;
    return s;
  endfunction

  function automatic int pos_of(input int sec, input int st, input int ld, input int off);
    return (sec * 32 + st + ld + off) % 192;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Reference model built from the requirements
  bit m_r1, m_r2;
  logic [2:0] m_hq;
  int m_cnt, m_intv, m_per, m_tick, m_step, m_sec;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r1 <= 0; m_r2 <= 0;
    end else begin
      m_r1 <= 1; m_r2 <= m_r1;
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !m_r2) begin
      m_hq <= 3'b000; m_cnt <= 0; m_intv <= CMAX; m_per <= CMAX >> 5;
      m_tick <= 0; m_step <= 0; m_sec <= 0;
    end else begin
      bit valid, edge_seen, smode;
      int inc;
      valid     = (hall_i != 3'b000) && (hall_i != 3'b111);
      edge_seen = valid && (hall_i != m_hq);
      inc       = (m_cnt == CMAX) ? CMAX : m_cnt + 1;
      smode     = sine_sel_i && !((m_intv > SLOW) || (m_cnt >= SLOW));
      if (edge_seen) begin
        m_hq <= hall_i; m_intv <= inc; m_per <= ((inc >> 5) == 0) ? 1 : (inc >> 5);
        m_cnt <= 0; m_tick <= 0; m_step <= 0; m_sec <= map_sector(hall_i, dir_i);
      end else begin
        m_cnt <= inc;
        if (!smode) begin
          m_tick <= 0; m_step <= 0;
        end else if (m_tick == m_per - 1) begin
          m_tick <= 0;
          m_step <= (m_step + 1) % 32;
          if (m_step == 31) m_sec <= (m_sec + 1) % 6;
        end else begin
          m_tick <= m_tick + 1;
        end
      end
    end
  end

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int pu, pv, pw;
      bit exp_mode;
      pu = pos_of(m_sec, m_step, lead_i, 0);
      pv = pos_of(m_sec, m_step, lead_i, 128);
      pw = pos_of(m_sec, m_step, lead_i, 64);
      exp_mode = sine_sel_i && !((m_intv > SLOW) || (m_cnt >= SLOW));
      chk({sector_u_o, step_u_o} == 8'(pu), "R8 model U", {sector_u_o, step_u_o}, pu);
      chk({sector_v_o, step_v_o} == 8'(pv), "R8 model V", {sector_v_o, step_v_o}, pv);
      chk({sector_w_o, step_w_o} == 8'(pw), "R8 model W", {sector_w_o, step_w_o}, pw);
      chk(sine_mode_o == exp_mode, "R10 model mode", sine_mode_o, exp_mode);
      chk(stall_o == (m_cnt == CMAX), "R11 model stall", stall_o, (m_cnt == CMAX));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      report();
    end
  end

  task automatic edge_to(input logic [2:0] h);
    @(negedge clk); #1 hall_i = h;
  endtask

  task automatic wait_m(input int m);
    repeat (m + 1) @(negedge clk);
  endtask

  logic [2:0] fwd [6] = '{3'b001, 3'b011, 3'b010, 3'b110, 3'b100, 3'b101};

  initial begin
    void'($urandom(32'h1a2b3c4d));
    repeat (5) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(sector_u_o == 0 && step_u_o == 0, "R1 U pointer", {sector_u_o, step_u_o}, 0);
    chk(sector_v_o == 4 && sector_w_o == 2, "R1 V/W sectors", {sector_v_o, sector_w_o}, {3'd4, 3'd2});
    chk(!sine_mode_o && !stall_o, "R1 mode/stall", {sine_mode_o, stall_o}, 0);

    #1 sine_sel_i = 1'b1;
    for (int i = 0; i < 7; i++) begin
      edge_to(fwd[i % 6]);
      wait_m(0);
      chk(sector_u_o == 3'(i % 6) && step_u_o == 0, "R3 realign", {sector_u_o, step_u_o}, (i % 6) * 32);
      repeat (25) @(negedge clk);
      if (i >= 1) chk(step_u_o == 2, "R2 step period 10", step_u_o, 2);
      repeat (293) @(negedge clk);
    end
    // R5: roll-over and edge coincide; Hall jumps two sectors
    edge_to(fwd[2]);
    wait_m(0);
    chk(sector_u_o == 2 && step_u_o == 0, "R5 edge wins", {sector_u_o, step_u_o}, 64);
    // R4: no further edge
    repeat (329) @(negedge clk);
    chk(sector_u_o == 3 && step_u_o == 0, "R4 roll-over", {sector_u_o, step_u_o}, 96);
    repeat (16) @(negedge clk);
    chk(sector_u_o == 3 && step_u_o == 2, "R4 same width", {sector_u_o, step_u_o}, 98);
    repeat (254) @(negedge clk);
    chk(sine_mode_o == 1, "R10 below limit", sine_mode_o, 1);
    @(negedge clk);
    chk(sine_mode_o == 0, "R10 at limit", sine_mode_o, 0);
    @(negedge clk);
    chk(step_u_o == 0, "R9 block hold", step_u_o, 0);
    repeat (421) @(negedge clk);
    chk(stall_o == 0, "R11 before saturation", stall_o, 0);
    @(negedge clk);
    chk(stall_o == 1, "R11 saturated", stall_o, 1);
    repeat (77) @(negedge clk);
    chk(stall_o == 1 && sine_mode_o == 0, "R11 stall held", {stall_o, sine_mode_o}, 2);
    edge_to(fwd[3]);
    wait_m(0);
    chk(stall_o == 0 && sine_mode_o == 0, "R11 edge after stall", {stall_o, sine_mode_o}, 0);
    repeat (318) @(negedge clk);
    edge_to(fwd[4]);
    wait_m(0);
    chk(sine_mode_o == 1, "R10 recovered", sine_mode_o, 1);
    // R7: invalid code ignored
    repeat (148) @(negedge clk);
    edge_to(3'b000);
    wait_m(0);
    chk(sector_u_o == 4 && step_u_o == 15, "R7 code 000 ignored", {sector_u_o, step_u_o}, 143);
    repeat (168) @(negedge clk);
    edge_to(fwd[5]);
    wait_m(0);
    chk(sector_u_o == 5 && step_u_o == 0, "R7 next valid accepted", {sector_u_o, step_u_o}, 160);
    // R9 sine deselected
    #1 sine_sel_i = 1'b0;
    repeat (100) @(negedge clk);
    chk(sine_mode_o == 0 && step_u_o == 0, "R9 deselected", {sine_mode_o, step_u_o}, 0);
    #1 sine_sel_i = 1'b1;
    // R6 reverse mapping
    #1 dir_i = 1'b1;
    edge_to(3'b011);
    wait_m(0);
    chk(sector_u_o == 5, "R6 reverse 011", sector_u_o, 5);
    edge_to(3'b100);
    wait_m(0);
    chk(sector_u_o == 2, "R6 reverse 100", sector_u_o, 2);
    // R8 lead and phase spacing
    #1 begin dir_i = 1'b0; lead_i = 5'd5; end
    edge_to(3'b110);
    wait_m(0);
    chk({sector_u_o, step_u_o} == {3'd3, 5'd5}, "R8 lead U", {sector_u_o, step_u_o}, 101);
    chk({sector_v_o, step_v_o} == {3'd1, 5'd5}, "R8 lead V", {sector_v_o, step_v_o}, 37);
    chk({sector_w_o, step_w_o} == {3'd5, 5'd5}, "R8 lead W", {sector_w_o, step_w_o}, 165);
    #1 lead_i = 5'd31;
    edge_to(3'b101);
    wait_m(0);
    chk({sector_u_o, step_u_o} == {3'd5, 5'd31}, "R8 wrap U", {sector_u_o, step_u_o}, 191);
    chk({sector_v_o, step_v_o} == {3'd3, 5'd31}, "R8 wrap V", {sector_v_o, step_v_o}, 127);
    chk({sector_w_o, step_w_o} == {3'd1, 5'd31}, "R8 wrap W", {sector_w_o, step_w_o}, 63);

    // Random phase, judged by the reference model
    for (int k = 0; k < 300; k++) begin
      int idx, gap;
      idx = $urandom_range(0, 5);
      @(negedge clk);
      #1 begin
        if ($urandom_range(0, 9) < 8) hall_i = fwd[idx];
        else hall_i = 3'($urandom_range(0, 7));
        lead_i = 5'($urandom_range(0, 31));
        if ($urandom_range(0, 19) == 0) dir_i = ~dir_i;
        sine_sel_i = ($urandom_range(0, 9) != 0);
      end
      gap = ($urandom_range(0, 9) == 0) ? $urandom_range(1, 3) : $urandom_range(30, 400);
      repeat (gap) @(negedge clk);
    end
    done = 1'b1;
    report();
  end
endmodule